// File: doc/BRIEF.md
# Four-Window Overlay Pixel Compositor

This block forms the final colour of each display pixel from up to four overlay windows laid over a programmable background colour. For every raster coordinate presented with a valid strobe, it first works out which enabled windows contain the coordinate. It then takes the 32-bit ARGB word offered for each window, passes that window's red, green and blue through the window's own 256-entry gamma table, and alpha-blends the layers bottom to top over the background.

Each window is placed by an origin and a size held in registers. Moving a window therefore only takes new register values, and the pixel source is left untouched. Fetching pixel data, generating display timing and driving the panel are left to neighbouring blocks. The result leaves a fixed-depth pipeline together with a matching valid strobe.

Top module: `ovl_compositor`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `out_valid` is 0 and `out_rgb` is 0. Every window is disabled and the background is 0x000000.
- R2: `out_valid` equals `pix_valid` delayed by exactly NWIN+1 clock cycles (5 with defaults). The matching `out_rgb` appears in that same cycle.
- R3: Window k covers pixel (x,y) only when it is enabled, x0 <= x < x0+w and y0 <= y < y0+h. A window with zero width or height covers nothing.
- R4: A disabled window has no effect on the output, whatever its pixel data and geometry.
- R5: Layers are composed in fixed order: background first, then window 0, 1, 2, 3. The highest-numbered covering window lands on top, so window 3 at alpha 0xFF hides everything beneath it.
- R6: Each blend step computes, per channel, floor((a*src + (255-a)*dst)/255). Here a is the window's 8-bit alpha (pixel bits [31:24]), src is the gamma-corrected window channel and dst is the result of the layers below.
- R7: The R (bits [23:16]), G ([15:8]) and B ([7:0]) channels of window k are all looked up in window k's gamma table before blending. Alpha is used uncorrected.
- R8: A pixel covered by no enabled window outputs the background colour, with R in bits [23:16], G in [15:8] and B in [7:0].
- R9: Writing new origin values moves a window. The same coordinate and pixel data then produce the new coverage result.
- R10: A register write with `reg_we`=1 selects its field by `reg_field`: 0 enable (`reg_wdata[0]`), 1 origin (x in [CW-1:0], y in [2CW-1:CW]), 2 size (w and h in the same positions), 3 background colour (`reg_wdata[23:0]`, `reg_win` ignored).
- R11: With `gam_we`=1, entry `gam_addr` of window `gam_win`'s table is set to `gam_data`. It is used from the next pixel onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_win | input | log2(NWIN) | Window addressed by the register write |
| reg_field | input | 2 | Field select: enable, origin, size, background |
| reg_wdata | input | max(2*CW,24) | Register write data |
| gam_we | input | 1 | Gamma table write strobe |
| gam_win | input | log2(NWIN) | Window whose gamma table is written |
| gam_addr | input | 8 | Gamma table entry index |
| gam_data | input | 8 | Gamma table entry value |
| pix_valid | input | 1 | Raster coordinate valid |
| pix_x | input | CW | Raster column |
| pix_y | input | CW | Raster row |
| win_pix | input | 32*NWIN | ARGB pixel per window, window k in bits [32k+31:32k] |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composited RGB pixel |

## Verification
Every composited pixel and its valid flag are due exactly NWIN+1 cycles (5 with defaults) after the pixel was presented. The bench keeps a shift line of that depth of expected results. At each falling edge it compares the outputs with the entry that has just left the line, so every check is made in the cycle the result is due. Register and gamma writes go in during cycles with no valid pixel. They are applied to the bench's model after the pixel of that cycle has been computed, so each expected value reflects exactly the settings the hardware saw at its first pipeline stage.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   typedef logic [7:0]  chan_t;
   typedef logic [23:0] rgb_t;

   // one window's contribution to a pixel after the lookup stage
   typedef struct packed {
      logic  cov;
      chan_t a;
      chan_t r;
      chan_t g;
      chan_t b;
   } layer_t;

   typedef enum logic [1:0] {
      FLD_ENABLE = 2'd0,
      FLD_ORIGIN = 2'd1,
      FLD_SIZE   = 2'd2,
      FLD_BACKGR = 2'd3
   } fld_e;

   // blend numerator a*s + (255-a)*d, at most 65025
   function automatic logic [15:0] mix_num(chan_t a, chan_t s, chan_t d);
      logic [15:0] inv;
      inv = 16'(8'd255 - a);
      return 16'(a) * 16'(s) + inv * 16'(d);
   endfunction

   function automatic chan_t div255_exact(logic [15:0] n);
      return chan_t'(n / 16'd255);
   endfunction

   // floor(n/255) for n <= 65025 with one add and two shifts
   function automatic chan_t div255_shift(logic [15:0] n);
      logic [16:0] t;
      t = 17'(n) + 17'd1 + 17'(n >> 8);
      return t[15:8];
   endfunction

endpackage

// File: rtl/ovl_cover.sv
module ovl_cover #(
   parameter int CW = 12
) (
   input  logic          en,
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   input  logic [CW-1:0] x0,
   input  logic [CW-1:0] y0,
   input  logic [CW-1:0] w,
   input  logic [CW-1:0] h,
   output logic          hit
);
   logic [CW:0] x_end;
   logic [CW:0] y_end;

   always_comb begin
      x_end = {1'b0, x0} + {1'b0, w};
      y_end = {1'b0, y0} + {1'b0, h};
      hit   = en
            && (x >= x0) && ({1'b0, x} < x_end)
            && (y >= y0) && ({1'b0, y} < y_end);
   end
endmodule

// File: rtl/ovl_gamma.sv
module ovl_gamma
   import ovl_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  chan_t         wdata,
   input  logic [AW-1:0] ra_r,
   input  logic [AW-1:0] ra_g,
   input  logic [AW-1:0] ra_b,
   output chan_t         q_r,
   output chan_t         q_g,
   output chan_t         q_b
);
   localparam int DEPTH = 1 << AW;

   chan_t tbl [DEPTH];

   always_ff @(posedge clk) begin
      if (we) tbl[waddr] <= wdata;
   end

   // three registered read ports, one per colour channel
   always_ff @(posedge clk) begin
      q_r <= tbl[ra_r];
      q_g <= tbl[ra_g];
      q_b <= tbl[ra_b];
   end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
   import ovl_pkg::*;
#(
   parameter bit SHIFT_DIV = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   i_v,
   input  layer_t i_lay,
   input  rgb_t   i_rgb,
   output logic   o_v,
   output rgb_t   o_rgb
);
   rgb_t src;
   rgb_t mixed;

   assign src = {i_lay.r, i_lay.g, i_lay.b};

   for (genvar c = 0; c < 3; c++) begin : g_ch
      logic [15:0] num;
      assign num = mix_num(i_lay.a, src[8*c +: 8], i_rgb[8*c +: 8]);
      if (SHIFT_DIV) begin : g_shift
         assign mixed[8*c +: 8] = div255_shift(num);
      end else begin : g_exact
         assign mixed[8*c +: 8] = div255_exact(num);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_v   <= 1'b0;
         o_rgb <= '0;
      end else begin
         o_v   <= i_v;
         o_rgb <= i_lay.cov ? mixed : i_rgb;
      end
   end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
   import ovl_pkg::*;
#(
   parameter int  NWIN      = 4,
   parameter int  CW        = 12,
   parameter bit  SHIFT_DIV = 1'b1,
   localparam int WIW       = (NWIN > 1) ? $clog2(NWIN) : 1,
   localparam int RW        = (2 * CW > 24) ? 2 * CW : 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [WIW-1:0]    reg_win,
   input  logic [1:0]        reg_field,
   input  logic [RW-1:0]     reg_wdata,
   input  logic              gam_we,
   input  logic [WIW-1:0]    gam_win,
   input  logic [7:0]        gam_addr,
   input  logic [7:0]        gam_data,
   input  logic              pix_valid,
   input  logic [CW-1:0]     pix_x,
   input  logic [CW-1:0]     pix_y,
   input  logic [32*NWIN-1:0] win_pix,
   output logic              out_valid,
   output logic [23:0]       out_rgb
);
   localparam int LAT = NWIN + 1;

   if (NWIN < 1 || NWIN > 8) begin : g_bad_nwin
      $error("ovl_compositor: NWIN must lie in 1..8");
   end
   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("ovl_compositor: CW must lie in 2..16");
   end

   fld_e                reg_fld;
   logic [NWIN-1:0]     win_en;
   logic [NWIN-1:0]     s1_cov;
   layer_t [NWIN-1:0]   s1_lay;
   logic                s1_v;
   rgb_t                s1_bg;
   rgb_t                bg_q;

   assign reg_fld = fld_e'(reg_field);

   // background colour register, shared by all windows
   always_ff @(posedge clk) begin
      if (!rst_n)                                  bg_q <= '0;
      else if (reg_we && reg_fld == FLD_BACKGR)    bg_q <= reg_wdata[23:0];
   end

   // stage 1 common part
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v  <= 1'b0;
         s1_bg <= '0;
      end else begin
         s1_v  <= pix_valid;
         s1_bg <= bg_q;
      end
   end

   // per-window geometry, coverage and gamma lookup
   for (genvar k = 0; k < NWIN; k++) begin : g_win
      logic          en_q;
      logic [CW-1:0] x0_q, y0_q, w_q, h_q;
      logic          hit;
      logic          cov_q;
      chan_t         a_q;
      chan_t         gr, gg, gb;
      logic          sel_w;
      logic [31:0]   px;

      assign sel_w = reg_we && (reg_win == WIW'(k));
      assign px    = win_pix[32*k +: 32];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q <= 1'b0;
            x0_q <= '0;
            y0_q <= '0;
            w_q  <= '0;
            h_q  <= '0;
         end else if (sel_w) begin
            case (reg_fld)
               FLD_ENABLE: en_q <= reg_wdata[0];
               FLD_ORIGIN: begin
                  x0_q <= reg_wdata[CW-1:0];
                  y0_q <= reg_wdata[2*CW-1:CW];
               end
               FLD_SIZE: begin
                  w_q <= reg_wdata[CW-1:0];
                  h_q <= reg_wdata[2*CW-1:CW];
               end
               default: ;
            endcase
         end
      end

      assign win_en[k] = en_q;

      ovl_cover #(.CW(CW)) u_cover (
         .en (en_q),
         .x  (pix_x),
         .y  (pix_y),
         .x0 (x0_q),
         .y0 (y0_q),
         .w  (w_q),
         .h  (h_q),
         .hit(hit)
      );

      ovl_gamma #(.AW(8)) u_gamma (
         .clk  (clk),
         .we   (gam_we && (gam_win == WIW'(k))),
         .waddr(gam_addr),
         .wdata(gam_data),
         .ra_r (px[23:16]),
         .ra_g (px[15:8]),
         .ra_b (px[7:0]),
         .q_r  (gr),
         .q_g  (gg),
         .q_b  (gb)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cov_q <= 1'b0;
            a_q   <= '0;
         end else begin
            cov_q <= hit;
            a_q   <= px[31:24];
         end
      end

      assign s1_cov[k] = cov_q;
      assign s1_lay[k] = {cov_q, a_q, gr, gg, gb};
   end

   // blend chain: stage k lays window k over the result of stages below
   logic st_v   [NWIN+1];
   rgb_t st_rgb [NWIN+1];

   assign st_v[0]   = s1_v;
   assign st_rgb[0] = s1_bg;

   for (genvar k = 0; k < NWIN; k++) begin : g_stage
      // window k is consumed k cycles after stage 1: align it
      layer_t dl [k+1];
      assign dl[0] = s1_lay[k];
      for (genvar j = 0; j < k; j++) begin : g_dly
         always_ff @(posedge clk) begin
            if (!rst_n) dl[j+1] <= '0;
            else        dl[j+1] <= dl[j];
         end
      end

      ovl_blend #(.SHIFT_DIV(SHIFT_DIV)) u_blend (
         .clk  (clk),
         .rst_n(rst_n),
         .i_v  (st_v[k]),
         .i_lay(dl[k]),
         .i_rgb(st_rgb[k]),
         .o_v  (st_v[k+1]),
         .o_rgb(st_rgb[k+1])
      );
   end

   assign out_valid = st_v[LAT-1];
   assign out_rgb   = st_rgb[LAT-1];
endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk
   import ovl_pkg::*;
#(
   parameter int NWIN = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pix_valid,
   input logic            out_valid,
   input logic [23:0]     out_rgb,
   input logic            s1_v,
   input logic [NWIN-1:0] s1_cov,
   input layer_t          s1_top,
   input rgb_t            s1_bg,
   input logic [NWIN-1:0] win_en
);
   localparam int LAT = NWIN + 1;

   // cycles since reset release, saturating at LAT
   logic [3:0] warm;
   always_ff @(posedge clk) begin
      if (!rst_n)                  warm <= '0;
      else if (int'(warm) < LAT)   warm <= warm + 4'd1;
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_rgb == 24'd0));

   // R2
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(warm) >= LAT) |-> (out_valid == $past(pix_valid, LAT)));

   // R4
   disabled_no_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(warm) >= 1) |-> ((s1_cov & ~$past(win_en)) == '0));

   // R8
   bare_background_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(warm) >= LAT && $past(s1_v && s1_cov == '0, NWIN))
      |-> (out_rgb == $past(s1_bg, NWIN)));

   // R5
   opaque_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(warm) >= LAT && $past(s1_v && s1_top.cov && s1_top.a == 8'hFF, NWIN))
      |-> (out_rgb == $past({s1_top.r, s1_top.g, s1_top.b}, NWIN)));
endmodule

bind ovl_compositor ovl_compositor_chk #(.NWIN(NWIN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pix_valid(pix_valid),
   .out_valid(out_valid),
   .out_rgb  (out_rgb),
   .s1_v     (s1_v),
   .s1_cov   (s1_cov),
   .s1_top   (s1_lay[NWIN-1]),
   .s1_bg    (s1_bg),
   .win_en   (win_en)
);

// File: tb/test_ovl_compositor.sv
module test_ovl_compositor;
   localparam int CLK_NS = 10;
   localparam int NW     = 4;
   localparam int CW     = 12;
   localparam int LAT    = NW + 1;
   localparam int RW     = 24;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              reg_we;
   logic [1:0]        reg_win;
   logic [1:0]        reg_field;
   logic [RW-1:0]     reg_wdata;
   logic              gam_we;
   logic [1:0]        gam_win;
   logic [7:0]        gam_addr;
   logic [7:0]        gam_data;
   logic              pix_valid;
   logic [CW-1:0]     pix_x;
   logic [CW-1:0]     pix_y;
   logic [32*NW-1:0]  win_pix;
   logic              out_valid;
   logic [23:0]       out_rgb;

   ovl_compositor #(.NWIN(NW), .CW(CW)) i_ovl_compositor (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_win(reg_win), .reg_field(reg_field), .reg_wdata(reg_wdata),
      .gam_we(gam_we), .gam_win(gam_win), .gam_addr(gam_addr), .gam_data(gam_data),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .win_pix(win_pix),
      .out_valid(out_valid), .out_rgb(out_rgb)
   );

   always #(CLK_NS / 2) clk = ~clk;

   // bench model of the programmed state
   logic        m_en [NW];
   int          m_x0 [NW], m_y0 [NW], m_w [NW], m_h [NW];
   logic [23:0] m_bg;
   logic [7:0]  gm [NW][256];

   // expected-result line, LAT deep
   logic        e_v   [LAT];
   logic [23:0] e_rgb [LAT];
   string       e_tag [LAT];

   // values for the next cycle
   logic        n_v, n_rwe, n_gwe;
   int          n_x, n_y, n_rwin, n_rfld, n_gwin, n_gaddr, n_gdat;
   logic [23:0] n_rdat;
   logic [127:0] n_pix;
   string       cur_tag;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  live  = 0;

   function automatic logic [7:0] bmix(int a, int s, int d);
      return 8'((a * s + (255 - a) * d) / 255);
   endfunction

   function automatic logic [23:0] model_px(int x, int y, logic [127:0] p);
      logic [23:0] c;
      c = m_bg;
      for (int k = 0; k < NW; k++) begin
         if (m_en[k] && x >= m_x0[k] && x < m_x0[k] + m_w[k]
                     && y >= m_y0[k] && y < m_y0[k] + m_h[k]) begin
            int a;
            a = int'(p[32*k+24 +: 8]);
            c = {bmix(a, int'(gm[k][p[32*k+16 +: 8]]), int'(c[23:16])),
                 bmix(a, int'(gm[k][p[32*k+8  +: 8]]), int'(c[15:8])),
                 bmix(a, int'(gm[k][p[32*k    +: 8]]), int'(c[7:0]))};
         end
      end
      return c;
   endfunction

   function automatic logic [127:0] setw(logic [127:0] p, int k, logic [31:0] argb);
      logic [127:0] q;
      q = p;
      q[32*k +: 32] = argb;
      return q;
   endfunction

   task automatic tick();
      @(negedge clk);
      if (live) begin
         n_chk++;
         if (out_valid !== e_v[LAT-1]) begin
            n_bad++;
            $display("FAIL R2: out_valid actual %0b expected %0b", out_valid, e_v[LAT-1]);
         end
         if (e_v[LAT-1]) begin
            n_chk++;
            if (out_rgb !== e_rgb[LAT-1]) begin
               n_bad++;
               $display("FAIL %s: out_rgb actual %06h expected %06h",
                        e_tag[LAT-1], out_rgb, e_rgb[LAT-1]);
            end
         end
      end
      for (int i = LAT - 1; i > 0; i--) begin
         e_v[i]   = e_v[i-1];
         e_rgb[i] = e_rgb[i-1];
         e_tag[i] = e_tag[i-1];
      end
      e_v[0]   = n_v;
      e_rgb[0] = n_v ? model_px(n_x, n_y, n_pix) : 24'd0;
      e_tag[0] = cur_tag;
      pix_valid = n_v;
      pix_x     = CW'(n_x);
      pix_y     = CW'(n_y);
      win_pix   = n_pix;
      reg_we    = n_rwe;
      reg_win   = 2'(n_rwin);
      reg_field = 2'(n_rfld);
      reg_wdata = n_rdat;
      gam_we    = n_gwe;
      gam_win   = 2'(n_gwin);
      gam_addr  = 8'(n_gaddr);
      gam_data  = 8'(n_gdat);
      // R10 field decode in the model
      if (n_rwe) begin
         case (n_rfld)
            0: m_en[n_rwin] = n_rdat[0];
            1: begin m_x0[n_rwin] = int'(n_rdat[11:0]); m_y0[n_rwin] = int'(n_rdat[23:12]); end
            2: begin m_w[n_rwin]  = int'(n_rdat[11:0]); m_h[n_rwin]  = int'(n_rdat[23:12]); end
            default: m_bg = n_rdat;
         endcase
      end
      if (n_gwe) gm[n_gwin][n_gaddr] = 8'(n_gdat);
   endtask

   task automatic wreg(int win, int fld, logic [23:0] data);
      n_rwe = 1'b1; n_rwin = win; n_rfld = fld; n_rdat = data;
      tick();
      n_rwe = 1'b0;
   endtask

   task automatic place(int win, int x0, int y0, int w, int h);
      wreg(win, 1, {12'(y0), 12'(x0)});
      wreg(win, 2, {12'(h), 12'(w)});
   endtask

   task automatic wgam(int win, int addr, int val);
      n_gwe = 1'b1; n_gwin = win; n_gaddr = addr; n_gdat = val;
      tick();
      n_gwe = 1'b0;
   endtask

   task automatic px(int x, int y, logic [127:0] p, string tag);
      n_v = 1'b1; n_x = x; n_y = y; n_pix = p; cur_tag = tag;
      tick();
      n_v = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finish_run();
   end

   initial begin
      logic [127:0] p;
      void'($urandom(32'd2718));
      rst_n = 1'b0;
      n_v = 0; n_rwe = 0; n_gwe = 0; n_x = 0; n_y = 0; n_pix = '0;
      n_rwin = 0; n_rfld = 0; n_rdat = '0; n_gwin = 0; n_gaddr = 0; n_gdat = 0;
      cur_tag = "R6";
      pix_valid = 0; pix_x = '0; pix_y = '0; win_pix = '0;
      reg_we = 0; reg_win = '0; reg_field = '0; reg_wdata = '0;
      gam_we = 0; gam_win = '0; gam_addr = '0; gam_data = '0;
      for (int k = 0; k < NW; k++) begin
         m_en[k] = 0; m_x0[k] = 0; m_y0[k] = 0; m_w[k] = 0; m_h[k] = 0;
      end
      m_bg = '0;
      for (int i = 0; i < LAT; i++) begin e_v[i] = 0; e_rgb[i] = '0; e_tag[i] = "R2"; end

      repeat (4) @(negedge clk);
      // R1: outputs quiet while in reset
      n_chk++;
      if (out_valid !== 1'b0 || out_rgb !== 24'd0) begin
         n_bad++;
         $display("FAIL R1: in reset actual %0b/%06h expected 0/000000", out_valid, out_rgb);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R1: still quiet the cycle after release
      n_chk++;
      if (out_valid !== 1'b0 || out_rgb !== 24'd0) begin
         n_bad++;
         $display("FAIL R1: after reset actual %0b/%06h expected 0/000000", out_valid, out_rgb);
      end
      live = 1;

      // R1: reset background is black and no window enabled
      px(3, 3, {4{32'hFF_AA_BB_CC}}, "R1");

      // R11: load every gamma table
      for (int k = 0; k < NW; k++) begin
         for (int i = 0; i < 256; i++) begin
            case (k)
               0: wgam(k, i, i);
               1: wgam(k, i, 255 - i);
               2: wgam(k, i, (i * i) / 255);
               default: wgam(k, i, (i >> 1) + 64);
            endcase
         end
      end

      // R8, R10: background field, window index ignored for it
      wreg(0, 3, 24'h20_30_40);
      px(5, 5, {4{32'hFF_11_22_33}}, "R8");
      wreg(2, 3, 24'h10_20_30);
      px(5, 5, {4{32'hFF_11_22_33}}, "R10");

      // R4: window placed over the pixel but disabled
      place(1, 0, 0, 50, 50);
      px(5, 5, {4{32'hFF_99_88_77}}, "R4");
      px(49, 49, setw('0, 1, 32'hFF_00_00_00), "R4");

      // R3: half-open coverage rectangle
      place(0, 10, 5, 4, 3);
      wreg(0, 0, 24'd1);
      p = setw('0, 0, 32'hFF_12_34_56);
      px(9, 5, p, "R3");
      px(10, 5, p, "R3");
      px(13, 7, p, "R3");
      px(14, 5, p, "R3");
      px(10, 4, p, "R3");
      px(10, 8, p, "R3");
      px(13, 8, p, "R3");
      // R3: zero-width window covers nothing
      place(3, 60, 60, 0, 5);
      wreg(3, 0, 24'd1);
      px(60, 60, setw('0, 3, 32'hFF_FF_FF_FF), "R3");
      wreg(3, 0, 24'd0);

      // R7: inverted table on window 1, alpha used raw
      place(1, 20, 20, 5, 5);
      wreg(1, 0, 24'd1);
      px(21, 21, setw('0, 1, 32'hFF_10_80_F0), "R7");
      px(22, 22, setw('0, 1, 32'h80_10_80_F0), "R7");
      px(24, 24, setw('0, 1, 32'h00_10_80_F0), "R7");
      // R11: single entry rewrite takes effect on the next pixel
      wgam(1, 16, 8'h5A);
      px(21, 21, setw('0, 1, 32'hFF_10_10_10), "R11");

      // R5: window 3 above window 2
      place(2, 30, 30, 4, 4);
      place(3, 31, 31, 4, 4);
      wreg(2, 0, 24'd1);
      wreg(3, 0, 24'd1);
      p = setw(setw('0, 2, 32'hFF_C0_40_80), 3, 32'hFF_20_60_A0);
      px(32, 32, p, "R5");
      px(30, 30, p, "R5");
      px(34, 34, p, "R5");
      p = setw(setw('0, 2, 32'hFF_C0_40_80), 3, 32'h00_20_60_A0);
      px(32, 32, p, "R5");

      // R6: partial alphas stacked on the background
      p = setw(setw('0, 2, 32'h40_FF_00_80), 3, 32'hC0_00_FF_40);
      px(32, 32, p, "R6");
      p = setw(setw('0, 2, 32'h7F_33_66_99), 3, 32'h01_FE_01_FE);
      px(33, 33, p, "R6");

      // R9: moving window 0 by origin writes only
      p = setw('0, 0, 32'hFF_55_66_77);
      place(0, 40, 10, 4, 3);
      px(40, 10, p, "R9");
      px(10, 5, p, "R9");
      wreg(0, 1, {12'd5, 12'd10});
      px(40, 10, p, "R9");
      px(10, 5, p, "R9");

      // R2: back-to-back and gapped valid pattern
      for (int i = 0; i < 6; i++) px(i, 30 + i, {4{32'h80_40_80_C0}}, "R2");
      idle(2);
      px(31, 32, {4{32'h80_40_80_C0}}, "R2");
      idle(1);

      // R6: random geometry, data and valid pattern
      for (int it = 0; it < 600; it++) begin
         if ($urandom % 8 == 0) begin
            int f;
            f = int'($urandom % 4);
            case (f)
               0: wreg(int'($urandom % 4), 0, 24'($urandom % 4 != 0));
               1: wreg(int'($urandom % 4), 1, {12'($urandom % 41), 12'($urandom % 41)});
               2: wreg(int'($urandom % 4), 2, {12'($urandom % 21), 12'($urandom % 21)});
               default: wreg(0, 3, 24'($urandom));
            endcase
         end else if ($urandom % 4 != 0) begin
            p = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom % 3 == 0) p[32*int'($urandom % 4) + 24 +: 8] = 8'hFF;
            px(int'($urandom % 48), int'($urandom % 48), p, "R6");
         end else begin
            idle(1);
         end
      end
      idle(LAT + 1);
      finish_run();
   end
endmodule